// File: doc/BRIEF.md
# USB OTG Interrupt Aggregator with End-of-Interrupt Gating

This block gathers every interrupt-worthy event of a USB OTG controller into one 32-bit raw source word, lets software gate that word with a mask, and drives one interrupt line to the processor. It has three event groups. The first is the transmit endpoints, including endpoint 0. The second is receive endpoints 1 and up. The third is a field of core USB events whose most significant bit is the VBUS-drive event. Events are sticky. A one-cycle pulse on an event input leaves its raw bit set until software clears it.

Software reaches the block through a simple 32-bit register bus. Reads are combinational and writes take effect at the clock edge. The raw word and the mask each have a pair of write-one-to-set and write-one-to-clear registers, so a driver never needs a read-modify-write. A masked view returns the pending events. Once the interrupt line goes high it stays high until software writes the end-of-interrupt register, whatever data it writes. After that write the line drops for a cycle and then rises again if anything is still pending. A revision word tells software that the block is clocked. Bit 0 of the control register returns the whole block to its reset state.

Top module: `usbirq_aggr`

## Requirements
- R1: Address 0x00 reads a nonzero revision constant (default 0x4EA10100). The control register at 0x04 always reads zero.
- R2: Bit placement is fixed. Transmit endpoint n is bit n (bits 4:0). Receive endpoint n (1..4) is bit 8+n (bits 12:9). Core event k is bit 16+k (bits 23:16). The VBUS-drive event is bit 24. All other bits, including bit 8, always read 0 in the raw and mask registers.
- R3: A high event input sets its raw bit (read at 0x20) from the next cycle on. The bit stays set until software clears it.
- R4: A write to 0x24 sets each raw bit written as 1. Bits written as 0, and positions that are not events, are unaffected.
- R5: A write to 0x28 clears each raw bit written as 1. When a hardware event and a clear hit the same bit in the same cycle, the bit stays set.
- R6: Writes to 0x30 set, and writes to 0x34 clear, the mask bits written as 1. The mask reads back at 0x2c.
- R7: Address 0x38 reads the raw word ANDed with the mask. With an empty mask the interrupt line stays low whatever the raw bits hold.
- R8: While the line is low and no end-of-interrupt write is made, a nonzero masked word raises the line at the next clock edge.
- R9: Once high, the line stays high until a write to 0x3c, even if every masked bit has been cleared.
- R10: A write to 0x3c with any data drops the line in the next cycle. The line rises again one cycle later only if the masked word is still nonzero. Otherwise it stays low until a new masked event.
- R11: Writing 0x04 with bit 0 set clears raw, mask and the line at the next edge, and this beats any event in the same cycle. Writing 0x04 with bit 0 clear has no effect.
- R12: Bit 0 of the status register at 0x08 follows the `vbus_drive_lvl` input. The other bits read 0.
- R13: After reset the raw word, the mask, the masked word and the line are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Bus access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not reading |
| ev_tx | input | TX_EP (5) | Transmit endpoint event pulses |
| ev_rx | input | RX_EP (4) | Receive endpoint event pulses, endpoint 1 first |
| ev_core | input | CORE_W-1 (8) | Core USB event pulses |
| ev_vbus | input | 1 | VBUS-drive event pulse |
| vbus_drive_lvl | input | 1 | Current VBUS-drive level for the status register |
| irq | output | 1 | Interrupt request, held until end-of-interrupt |

## Verification
A reference model in the bench tracks raw, mask and line state every cycle. It is driven first by directed patterns and then by a long random mix of bus writes, reads and sparse event pulses. Single-bit events in each field separate the three field offsets and the unused bit 8. Full-word set and clear writes show which positions are live. A clear that collides with an event on the same bit tells the hardware-wins rule apart from clear-wins. End-of-interrupt writes are made both with pending bits left and with none, which separates re-fire from stay-low. The same is done before and after the mask is emptied, which separates the held line from a plain level follower. A control write with bit 0 clear and one with bit 0 set show that only the set bit resets the block.

// File: rtl/usbirq_pkg.sv
package usbirq_pkg;

   localparam int unsigned WORD_W = 32;
   typedef logic [WORD_W-1:0] word_t;

   // register offsets (byte addresses)
   localparam logic [7:0] OFS_REV     = 8'h00;
   localparam logic [7:0] OFS_CTRL    = 8'h04;
   localparam logic [7:0] OFS_STAT    = 8'h08;
   localparam logic [7:0] OFS_RAW     = 8'h20;
   localparam logic [7:0] OFS_RAW_SET = 8'h24;
   localparam logic [7:0] OFS_RAW_CLR = 8'h28;
   localparam logic [7:0] OFS_MSK     = 8'h2c;
   localparam logic [7:0] OFS_MSK_SET = 8'h30;
   localparam logic [7:0] OFS_MSK_CLR = 8'h34;
   localparam logic [7:0] OFS_PEND    = 8'h38;
   localparam logic [7:0] OFS_EOI     = 8'h3c;

   // decoded write actions for one bus cycle
   typedef struct packed {
      word_t raw_set;
      word_t raw_clr;
      word_t msk_set;
      word_t msk_clr;
      logic  eoi;
      logic  soft_rst;
   } wr_cmd_t;

   function automatic word_t field_mask(int unsigned lsb, int unsigned width);
      word_t m;
      m = '0;
      for (int unsigned i = 0; i < WORD_W; i++) begin
         if (i >= lsb && i < lsb + width) m[i] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/usbirq_regif.sv
module usbirq_regif
   import usbirq_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter logic [31:0] REV_ID = 32'h4EA1_0100
) (
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  word_t             bus_wdata,
   input  logic              stat_lvl,
   input  word_t             raw,
   input  word_t             mask,
   input  word_t             pend,
   output wr_cmd_t           cmd,
   output word_t             bus_rdata
);

   localparam logic [ADDR_W-1:0] A_REV     = ADDR_W'(OFS_REV);
   localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_STAT    = ADDR_W'(OFS_STAT);
   localparam logic [ADDR_W-1:0] A_RAW     = ADDR_W'(OFS_RAW);
   localparam logic [ADDR_W-1:0] A_RAW_SET = ADDR_W'(OFS_RAW_SET);
   localparam logic [ADDR_W-1:0] A_RAW_CLR = ADDR_W'(OFS_RAW_CLR);
   localparam logic [ADDR_W-1:0] A_MSK     = ADDR_W'(OFS_MSK);
   localparam logic [ADDR_W-1:0] A_MSK_SET = ADDR_W'(OFS_MSK_SET);
   localparam logic [ADDR_W-1:0] A_MSK_CLR = ADDR_W'(OFS_MSK_CLR);
   localparam logic [ADDR_W-1:0] A_PEND    = ADDR_W'(OFS_PEND);
   localparam logic [ADDR_W-1:0] A_EOI     = ADDR_W'(OFS_EOI);

   logic wen;
   logic ren;

   assign wen = bus_valid & bus_write;
   assign ren = bus_valid & ~bus_write;

   always_comb begin
      cmd = '0;
      if (wen) begin
         case (bus_addr)
            A_RAW_SET: cmd.raw_set  = bus_wdata;
            A_RAW_CLR: cmd.raw_clr  = bus_wdata;
            A_MSK_SET: cmd.msk_set  = bus_wdata;
            A_MSK_CLR: cmd.msk_clr  = bus_wdata;
            A_CTRL:    cmd.soft_rst = bus_wdata[0];
            A_EOI:     cmd.eoi      = 1'b1;
            default:   cmd          = '0;
         endcase
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (ren) begin
         case (bus_addr)
            A_REV:   bus_rdata = REV_ID;
            A_STAT:  bus_rdata = word_t'(stat_lvl);
            A_RAW:   bus_rdata = raw;
            A_MSK:   bus_rdata = mask;
            A_PEND:  bus_rdata = pend;
            default: bus_rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/usbirq_srcbank.sv
module usbirq_srcbank
   import usbirq_pkg::*;
#(
   parameter logic [31:0] LIVE_BITS = 32'h01FF_1E1F
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  soft_rst,
   input  word_t hw_ev,
   input  word_t raw_set,
   input  word_t raw_clr,
   input  word_t msk_set,
   input  word_t msk_clr,
   output word_t raw_q,
   output word_t mask_q
);

   word_t raw_d;
   word_t mask_d;

   // hardware events are ORed in after the clear, so they win a collision
   always_comb begin
      raw_d  = (((raw_q & ~raw_clr) | raw_set) | hw_ev) & LIVE_BITS;
      mask_d = ((mask_q & ~msk_clr) | msk_set) & LIVE_BITS;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_q  <= '0;
         mask_q <= '0;
      end else if (soft_rst) begin
         raw_q  <= '0;
         mask_q <= '0;
      end else begin
         raw_q  <= raw_d;
         mask_q <= mask_d;
      end
   end

endmodule

// File: rtl/usbirq_eoi_gate.sv
module usbirq_eoi_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic soft_rst,
   input  logic eoi,
   input  logic pend_any,
   output logic irq
);

   logic fired_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fired_q <= 1'b0;
      end else if (soft_rst || eoi) begin
         fired_q <= 1'b0;
      end else if (pend_any) begin
         fired_q <= 1'b1;
      end
   end

   assign irq = fired_q;

endmodule

// File: rtl/usbirq_aggr.sv
module usbirq_aggr
   import usbirq_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned TX_EP    = 5,
   parameter int unsigned RX_EP    = 4,
   parameter int unsigned RX_BASE  = 8,
   parameter int unsigned CORE_LSB = 16,
   parameter int unsigned CORE_W   = 9,
   parameter logic [31:0] REV_ID   = 32'h4EA1_0100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [TX_EP-1:0]  ev_tx,
   input  logic [RX_EP-1:0]  ev_rx,
   input  logic [CORE_W-2:0] ev_core,
   input  logic              ev_vbus,
   input  logic              vbus_drive_lvl,
   output logic              irq
);

   localparam int unsigned RX_LSB   = RX_BASE + 1;
   localparam int unsigned VBUS_BIT = CORE_LSB + CORE_W - 1;
   localparam word_t TX_FIELD   = field_mask(0, TX_EP);
   localparam word_t RX_FIELD   = field_mask(RX_LSB, RX_EP);
   localparam word_t CORE_FIELD = field_mask(CORE_LSB, CORE_W);
   localparam word_t LIVE_BITS  = TX_FIELD | RX_FIELD | CORE_FIELD;

   // elaboration-time parameter checks
   generate
      if (ADDR_W < 6) begin : g_bad_addr
         $error("usbirq_aggr: ADDR_W must reach offset 0x3c");
      end
      if (TX_EP < 1 || TX_EP > RX_BASE + 1) begin : g_bad_tx
         $error("usbirq_aggr: transmit field overlaps receive field");
      end
      if (RX_EP < 1 || RX_LSB + RX_EP > CORE_LSB) begin : g_bad_rx
         $error("usbirq_aggr: receive field overlaps core field");
      end
      if (CORE_W < 2 || CORE_LSB + CORE_W > WORD_W) begin : g_bad_core
         $error("usbirq_aggr: core field does not fit the word");
      end
      if (REV_ID == 32'h0) begin : g_bad_rev
         $error("usbirq_aggr: revision constant must be nonzero");
      end
   endgenerate

   word_t   hw_ev;
   word_t   raw_q;
   word_t   mask_q;
   word_t   pend;
   wr_cmd_t cmd;
   logic    wr_eoi;
   logic    wr_soft;
   logic    valid_hold;

   always_comb begin
      hw_ev                         = '0;
      hw_ev[TX_EP-1:0]              = ev_tx;
      hw_ev[RX_LSB +: RX_EP]        = ev_rx;
      hw_ev[CORE_LSB +: CORE_W - 1] = ev_core;
      hw_ev[VBUS_BIT]               = ev_vbus;
   end

   assign pend    = raw_q & mask_q;
   assign wr_eoi  = cmd.eoi;
   assign wr_soft = cmd.soft_rst;
   assign valid_hold = |LIVE_BITS;

   usbirq_regif #(
      .ADDR_W (ADDR_W),
      .REV_ID (REV_ID)
   ) u_regif (
      .bus_valid (bus_valid),
      .bus_write (bus_write),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .stat_lvl  (vbus_drive_lvl),
      .raw       (raw_q),
      .mask      (mask_q),
      .pend      (pend),
      .cmd       (cmd),
      .bus_rdata (bus_rdata)
   );

   usbirq_srcbank #(
      .LIVE_BITS (LIVE_BITS)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (wr_soft),
      .hw_ev    (hw_ev),
      .raw_set  (cmd.raw_set),
      .raw_clr  (cmd.raw_clr),
      .msk_set  (cmd.msk_set),
      .msk_clr  (cmd.msk_clr),
      .raw_q    (raw_q),
      .mask_q   (mask_q)
   );

   usbirq_eoi_gate u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (wr_soft),
      .eoi      (wr_eoi),
      .pend_any (|pend & valid_hold),
      .irq      (irq)
   );

endmodule

// File: rtl/usbirq_aggr_chk.sv
module usbirq_aggr_chk
   import usbirq_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter logic [31:0] LIVE_BITS = 32'h01FF_1E1F
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_valid,
   input logic              bus_write,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_rdata,
   input logic              irq,
   input logic              eoi,
   input logic              soft_rst,
   input logic [31:0]       hw_ev,
   input logic [31:0]       raw,
   input logic [31:0]       mask,
   input logic [31:0]       pend
);

   // R2: positions outside the three fields never hold state
   a_r2_dead_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ((raw & ~LIVE_BITS) == 32'h0) && ((mask & ~LIVE_BITS) == 32'h0));

   // R3 and R5: an event bit is set after the edge, even against a clear
   a_r3_event_sets_raw: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_ev != 32'h0 && !soft_rst) |=> ((raw & $past(hw_ev)) == $past(hw_ev)));

   // R7: the masked view read on the bus matches the two registers
   a_r7_pend_read: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write && bus_addr == ADDR_W'(OFS_PEND)) |->
         (bus_rdata == (raw & mask)));

   // R8: a pending masked event raises a low line
   a_r8_fires: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq && pend != 32'h0 && !eoi && !soft_rst) |=> irq);

   // R9: the line holds until the end-of-interrupt write
   a_r9_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !eoi && !soft_rst) |=> irq);

   // R10: end-of-interrupt drops the line for one cycle
   a_r10_eoi_drops: assert property (@(posedge clk) disable iff (!rst_n)
      eoi |=> !irq);

   // R10: with nothing pending a low line stays low
   a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq && pend == 32'h0) |=> !irq);

   // R11: soft reset empties raw and mask and drops the line
   a_r11_soft_clears: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (raw == 32'h0 && mask == 32'h0 && !irq));

endmodule

bind usbirq_aggr usbirq_aggr_chk #(
   .ADDR_W    (ADDR_W),
   .LIVE_BITS (LIVE_BITS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_valid (bus_valid),
   .bus_write (bus_write),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .irq       (irq),
   .eoi       (wr_eoi),
   .soft_rst  (wr_soft),
   .hw_ev     (hw_ev),
   .raw       (raw_q),
   .mask      (mask_q),
   .pend      (pend)
);

// File: tb/usbirq_aggr_test.sv
module usbirq_aggr_test;

   localparam int          CLK_PERIOD = 10;
   localparam logic [31:0] EXP_REV    = 32'h4EA1_0100;
   localparam logic [31:0] LIVE       = 32'h01FF_1E1F;

   logic        clk;
   logic        rst_n;
   logic        bus_valid;
   logic        bus_write;
   logic [7:0]  bus_addr;
   logic [31:0] bus_wdata;
   logic [31:0] bus_rdata;
   logic [4:0]  ev_tx;
   logic [3:0]  ev_rx;
   logic [7:0]  ev_core;
   logic        ev_vbus;
   logic        vbus_drive_lvl;
   logic        irq;

   usbirq_aggr uut (
      .clk            (clk),
      .rst_n          (rst_n),
      .bus_valid      (bus_valid),
      .bus_write      (bus_write),
      .bus_addr       (bus_addr),
      .bus_wdata      (bus_wdata),
      .bus_rdata      (bus_rdata),
      .ev_tx          (ev_tx),
      .ev_rx          (ev_rx),
      .ev_core        (ev_core),
      .ev_vbus        (ev_vbus),
      .vbus_drive_lvl (vbus_drive_lvl),
      .irq            (irq)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   // reference model state
   logic [31:0] m_raw;
   logic [31:0] m_mask;
   logic        m_fired;
   int          n_chk;
   int          n_fail;
   string       cur_tag;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_rd(input logic [7:0] a);
      case (a)
         8'h00:   return EXP_REV;
         8'h08:   return {31'h0, vbus_drive_lvl};
         8'h20:   return m_raw;
         8'h2c:   return m_mask;
         8'h38:   return m_raw & m_mask;
         default: return 32'h0;
      endcase
   endfunction

   // one clock: optional read check, model update at the edge, line check after
   task automatic tick();
      logic        wr;
      logic        nf;
      logic [31:0] ev;
      logic [31:0] s;
      logic [31:0] c;
      logic [31:0] ms;
      logic [31:0] mc;
      #1;
      if (bus_valid && !bus_write) chk({cur_tag, " read"}, bus_rdata, exp_rd(bus_addr));
      @(posedge clk);
      wr = bus_valid && bus_write;
      ev = {7'h0, ev_vbus, ev_core, 3'h0, ev_rx, 4'h0, ev_tx};
      s  = (wr && bus_addr == 8'h24) ? bus_wdata : 32'h0;
      c  = (wr && bus_addr == 8'h28) ? bus_wdata : 32'h0;
      ms = (wr && bus_addr == 8'h30) ? bus_wdata : 32'h0;
      mc = (wr && bus_addr == 8'h34) ? bus_wdata : 32'h0;
      if (!rst_n || (wr && bus_addr == 8'h04 && bus_wdata[0])) begin
         m_raw = 32'h0; m_mask = 32'h0; m_fired = 1'b0;
      end else begin
         nf      = (wr && bus_addr == 8'h3c) ? 1'b0 : (m_fired || ((m_raw & m_mask) != 32'h0));
         m_raw   = ((m_raw & ~c) | (s & LIVE)) | ev;
         m_mask  = (m_mask & ~mc) | (ms & LIVE);
         m_fired = nf;
      end
      @(negedge clk);
      chk({cur_tag, " irq"}, {31'h0, irq}, {31'h0, m_fired});
      bus_valid = 1'b0; bus_write = 1'b0; bus_addr = 8'h0; bus_wdata = 32'h0;
      ev_tx = '0; ev_rx = '0; ev_core = '0; ev_vbus = 1'b0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      tick();
   endtask

   task automatic rd_lit(input logic [7:0] a, input logic [31:0] exp, input string tag);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      #1 chk(tag, bus_rdata, exp);
      tick();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic irq_is(input logic exp, input string tag);
      chk(tag, {31'h0, irq}, {31'h0, exp});
   endtask

   task automatic finish_run();
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_fail++;
      $display("FAIL R13 watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [7:0] addrs [11];
      n_chk = 0; n_fail = 0;
      m_raw = 32'h0; m_mask = 32'h0; m_fired = 1'b0;
      cur_tag = "R13";
      rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; bus_addr = 8'h0; bus_wdata = 32'h0;
      ev_tx = '0; ev_rx = '0; ev_core = '0; ev_vbus = 1'b0; vbus_drive_lvl = 1'b0;
      @(negedge clk);
      idle(3);
      rst_n = 1'b1;

      // R13: reset state, R1: identity registers
      rd_lit(8'h20, 32'h0, "R13 raw");
      rd_lit(8'h2c, 32'h0, "R13 mask");
      rd_lit(8'h38, 32'h0, "R13 masked");
      irq_is(1'b0, "R13 line");
      rd_lit(8'h00, EXP_REV, "R1 revision");
      wr(8'h04, 32'h0);
      rd_lit(8'h04, 32'h0, "R1 control");

      // R12: status follows the drive level
      cur_tag = "R12";
      vbus_drive_lvl = 1'b1;
      rd_lit(8'h08, 32'h1, "R12 level high");
      vbus_drive_lvl = 1'b0;
      rd_lit(8'h08, 32'h0, "R12 level low");

      // R3, R2: events land in their fields and stick
      cur_tag = "R3";
      ev_tx = 5'b01000; tick();
      rd_lit(8'h20, 32'h0000_0008, "R3 tx ep3");
      idle(2);
      rd_lit(8'h20, 32'h0000_0008, "R3 sticky");
      cur_tag = "R2";
      ev_rx = 4'b0001; tick();
      rd_lit(8'h20, 32'h0000_0208, "R2 rx ep1 at bit9");
      ev_rx = 4'b1111; ev_core = 8'hFF; ev_vbus = 1'b1; tick();
      rd_lit(8'h20, 32'h01FF_1E08, "R2 all fields");
      irq_is(1'b0, "R7 empty mask keeps line low");

      // R5, R4: clear and set registers
      cur_tag = "R5";
      wr(8'h28, 32'hFFFF_FFFF);
      rd_lit(8'h20, 32'h0, "R5 clear all");
      cur_tag = "R4";
      wr(8'h24, 32'hFFFF_FFFF);
      rd_lit(8'h20, LIVE, "R4 set only live bits");
      wr(8'h24, 32'h0);
      rd_lit(8'h20, LIVE, "R4 zero write no effect");
      cur_tag = "R5";
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 8'h28; bus_wdata = 32'h1;
      ev_tx = 5'b00001; tick();
      rd_lit(8'h20, LIVE, "R5 event beats clear");
      wr(8'h28, 32'h0000_1E1F);
      rd_lit(8'h20, 32'h01FF_0000, "R5 partial clear");

      // R6, R7, R8: mask and firing
      cur_tag = "R6";
      wr(8'h30, 32'h0001_0000);
      rd_lit(8'h2c, 32'h0001_0000, "R6 mask set");
      irq_is(1'b1, "R8 line raised");
      rd_lit(8'h38, 32'h0001_0000, "R7 masked view");

      // R9: held through mask and source clears
      cur_tag = "R9";
      wr(8'h34, 32'h0001_0000);
      rd_lit(8'h2c, 32'h0, "R6 mask clear");
      wr(8'h28, 32'hFFFF_FFFF);
      irq_is(1'b1, "R9 held after clears");
      idle(3);
      irq_is(1'b1, "R9 still held");

      // R10: EOI with nothing pending
      cur_tag = "R10";
      wr(8'h3c, 32'h1234_5678);
      irq_is(1'b0, "R10 dropped by eoi");
      idle(3);
      irq_is(1'b0, "R10 stays low");

      // R10: EOI with a source still pending
      wr(8'h30, 32'h0000_001F);
      wr(8'h24, 32'h0000_0004);
      tick();
      irq_is(1'b1, "R8 refire on new event");
      wr(8'h3c, 32'h0);
      irq_is(1'b0, "R10 low one cycle");
      tick();
      irq_is(1'b1, "R10 high again while pending");

      // R11: soft reset
      cur_tag = "R11";
      wr(8'h04, 32'h0000_0002);
      rd_lit(8'h20, 32'h0000_0004, "R11 bit0 clear ignored");
      irq_is(1'b1, "R11 line kept");
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h1;
      ev_tx = 5'b11111; tick();
      irq_is(1'b0, "R11 line cleared");
      rd_lit(8'h20, 32'h0, "R11 raw cleared");
      rd_lit(8'h2c, 32'h0, "R11 mask cleared");

      // random mix against the model
      cur_tag = "R3/R5/R6/R8/R9/R10";
      addrs = '{8'h20, 8'h24, 8'h28, 8'h2c, 8'h30, 8'h34, 8'h38, 8'h3c, 8'h08, 8'h00, 8'h04};
      for (int i = 0; i < 600; i++) begin
         int op;
         op = int'($urandom % 11);
         bus_valid = ($urandom % 4) != 0;
         bus_write = ($urandom % 2) != 0;
         bus_addr  = addrs[op];
         bus_wdata = $urandom & $urandom;
         if (op == 10 && bus_write && ($urandom % 8) != 0) bus_wdata[0] = 1'b0;
         if (($urandom % 3) == 0) begin
            ev_tx   = 5'($urandom & $urandom);
            ev_rx   = 4'($urandom & $urandom);
            ev_core = 8'($urandom & $urandom & $urandom);
            ev_vbus = ($urandom % 8) == 0;
         end
         vbus_drive_lvl = ($urandom % 2) != 0;
         tick();
      end

      finish_run();
   end

endmodule